// File: doc/BRIEF.md
# Edge-Triggered Timestamp Capture Unit

This block takes a snapshot of a free-running timer at the moment a selected transition shows up on an asynchronous input pin. Software picks the transitions that count: rising only, falling only, or any transition. Setting both selections to zero leaves the unit idle. Each accepted transition copies the whole timer word into a capture register and sets a sticky event flag. The flag is cleared only by an explicit software clear strobe.

The pin is first passed through a synchronizer chain. A transition is found by comparing the last synchronized sample with the one before it. The block can raise an interrupt request. That request follows the event flag, gated by an enable bit. Servicing the interrupt does not touch the flag. A later capture overwrites the stored timestamp whether or not software has read it.

Top module: `tscap_unit`

## Requirements
- R1: After a synchronous reset, `cap_value` is 0x0000 and both `evt_flag` and `irq_req` are 0.
- R2: With `edge_rise_en`=1 and `edge_fall_en`=0, a 0-to-1 change on `cap_pin` causes a capture and a 1-to-0 change does not.
- R3: With `edge_fall_en`=1 and `edge_rise_en`=0, a 1-to-0 change on `cap_pin` causes a capture and a 0-to-1 change does not.
- R4: With both edge enables at 1, every change of `cap_pin` in either direction causes a capture.
- R5: With both edge enables at 0, no change of `cap_pin` alters `cap_value` or `evt_flag`.
- R6: A capture loads all 16 bits of `timer_val` into `cap_value`. The timer is sampled at the third rising clock edge after the pin change becomes visible at the first synchronizer flop, and the result shows on `cap_value` right after that edge.
- R7: Every capture sets `evt_flag` on the same edge that loads `cap_value`. Once set, the flag stays at 1 until a clear strobe arrives.
- R8: A one-cycle pulse on `flag_clr` with no capture on that edge drives `evt_flag` to 0 on that edge.
- R9: When a capture and `flag_clr` fall on the same edge, `evt_flag` ends at 1.
- R10: `irq_req` is 1 exactly when `evt_flag` is 1 and `irq_en` is 1.
- R11: A second capture overwrites the first stored value even if the flag was never cleared.
- R12: Between captures, `cap_value` holds its value while `timer_val` keeps changing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Asynchronous trigger input |
| timer_val | input | 16 | Free-running timer value to be stamped |
| edge_rise_en | input | 1 | Accept 0-to-1 transitions |
| edge_fall_en | input | 1 | Accept 1-to-0 transitions |
| irq_en | input | 1 | Let the event flag raise the interrupt |
| flag_clr | input | 1 | Software clear strobe for the event flag |
| cap_value | output | 16 | Most recently captured timer value |
| evt_flag | output | 1 | Sticky capture event flag |
| irq_req | output | 1 | Interrupt request |

## Verification
A pin change driven just after a falling clock edge reaches the first synchronizer flop at the next rising edge. It reaches the second flop one edge later, and that is when the transition is detected. The capture register and the flag then update on the third rising edge. The bench therefore holds the pin steady for three rising edges and reads `cap_value`, `evt_flag` and `irq_req` at the falling edge that follows. It changes `timer_val` only at the falling edge before the sampling edge, so the stamped value is known exactly. A clear strobe acts on the single rising edge it spans and is checked at the next falling edge. The set-wins case places the strobe over the third edge of a capture.

// File: rtl/tscap_pkg.sv
package tscap_pkg;

    typedef struct packed {
        logic on_rise;
        logic on_fall;
        logic irq_en;
    } tscap_mode_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } tscap_edges_t;

    function automatic tscap_edges_t tscap_detect(logic cur, logic prev);
        tscap_edges_t e;
        e.rise = cur & ~prev;
        e.fall = ~cur & prev;
        return e;
    endfunction

    function automatic logic tscap_fires(tscap_mode_t m, tscap_edges_t e);
        return (m.on_rise & e.rise) | (m.on_fall & e.fall);
    endfunction

endpackage

// File: rtl/tscap_edge.sv
module tscap_edge
    import tscap_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pin,
    output tscap_edges_t edges
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= pin;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[LAST-1:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[LAST];
    end

    assign edges = tscap_detect(chain[LAST], prev);
endmodule

// File: rtl/tscap_capreg.sv
module tscap_capreg #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] din,
    output logic [TW-1:0] dout
);
    always_ff @(posedge clk) begin
        if (rst)       dout <= '0;
        else if (load) dout <= din;
    end
endmodule

// File: rtl/tscap_flag.sv
module tscap_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assign irq = flag & irq_en;
endmodule

// File: rtl/tscap_unit.sv
module tscap_unit
    import tscap_pkg::*;
#(
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_pin,
    input  logic [TW-1:0] timer_val,
    input  logic          edge_rise_en,
    input  logic          edge_fall_en,
    input  logic          irq_en,
    input  logic          flag_clr,
    output logic [TW-1:0] cap_value,
    output logic          evt_flag,
    output logic          irq_req
);
    tscap_mode_t  mode;
    tscap_edges_t edges;
    logic         cap_hit;

    assign mode.on_rise = edge_rise_en;
    assign mode.on_fall = edge_fall_en;
    assign mode.irq_en  = irq_en;

    tscap_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .pin   (cap_pin),
        .edges (edges)
    );

    assign cap_hit = tscap_fires(mode, edges);

    tscap_capreg #(.TW(TW)) u_capreg (
        .clk  (clk),
        .rst  (rst),
        .load (cap_hit),
        .din  (timer_val),
        .dout (cap_value)
    );

    tscap_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set    (cap_hit),
        .clr    (flag_clr),
        .irq_en (mode.irq_en),
        .flag   (evt_flag),
        .irq    (irq_req)
    );
endmodule

// File: rtl/tscap_unit_chk.sv
module tscap_unit_chk #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          edge_rise_en,
    input logic          edge_fall_en,
    input logic          flag_clr,
    input logic [TW-1:0] timer_val,
    input logic          hit,
    input logic [TW-1:0] cap_value,
    input logic          evt_flag
);
    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!edge_rise_en && !edge_fall_en) |-> !hit);

    p_load_r6: assert property (@(posedge clk) disable iff (rst)
        hit |=> cap_value == $past(timer_val));

    p_set_r7: assert property (@(posedge clk) disable iff (rst)
        hit |=> evt_flag);

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (evt_flag && !flag_clr) |=> evt_flag);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !hit) |=> !evt_flag);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && hit) |=> evt_flag);

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(cap_value));
endmodule

bind tscap_unit tscap_unit_chk #(.TW(TW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .edge_rise_en (edge_rise_en),
    .edge_fall_en (edge_fall_en),
    .flag_clr     (flag_clr),
    .timer_val    (timer_val),
    .hit          (cap_hit),
    .cap_value    (cap_value),
    .evt_flag     (evt_flag)
);

// File: tb/tscap_unit_tb.sv
module tscap_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_pin = 1'b0;
    logic [15:0] timer_val = '0;
    logic        edge_rise_en = 1'b0;
    logic        edge_fall_en = 1'b0;
    logic        irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic [15:0] cap_value;
    logic        evt_flag;
    logic        irq_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [15:0] exp_val = '0;
    logic        exp_flag = 1'b0;
    logic        pin_lvl = 1'b0;

    always #4 clk = ~clk;

    tscap_unit u_dut (
        .clk          (clk),
        .rst          (rst),
        .cap_pin      (cap_pin),
        .timer_val    (timer_val),
        .edge_rise_en (edge_rise_en),
        .edge_fall_en (edge_fall_en),
        .irq_en       (irq_en),
        .flag_clr     (flag_clr),
        .cap_value    (cap_value),
        .evt_flag     (evt_flag),
        .irq_req      (irq_req)
    );

    function automatic logic exp_hit(logic r, logic f, logic oldp, logic newp);
        return (r && !oldp && newp) || (f && oldp && !newp);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk({req, " value"}, {16'h0, cap_value}, {16'h0, exp_val});
        chk({req, " flag"}, {31'h0, evt_flag}, {31'h0, exp_flag});
        chk("R10 irq", {31'h0, irq_req}, {31'h0, exp_flag & irq_en});
    endtask

    // Drive a pin level; timer changes each cycle, stamp value set before 3rd edge.
    // When clr_on_third is set, the clear strobe covers the capture edge.
    task automatic pin_event(input logic newp, input logic [15:0] stamp,
                             input logic clr_on_third, input string req);
        logic hit;
        @(negedge clk);
        cap_pin   = newp;
        timer_val = ~stamp;
        @(posedge clk);
        @(negedge clk);
        timer_val = stamp ^ 16'h00ff;
        @(posedge clk);
        @(negedge clk);
        timer_val = stamp;
        flag_clr  = clr_on_third;
        @(posedge clk);
        @(negedge clk);
        flag_clr  = 1'b0;
        timer_val = stamp + 16'd7;
        hit = exp_hit(edge_rise_en, edge_fall_en, pin_lvl, newp);
        pin_lvl = newp;
        if (hit) begin
            exp_val  = stamp;
            exp_flag = 1'b1;
        end else if (clr_on_third) begin
            exp_flag = 1'b0;
        end
        check_all(req);
    endtask

    task automatic pulse_clear(input string req);
        @(negedge clk);
        flag_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flag_clr = 1'b0;
        exp_flag = 1'b0;
        check_all(req);
    endtask

    task automatic set_mode(input logic r, input logic f, input logic ie);
        @(negedge clk);
        edge_rise_en = r;
        edge_fall_en = f;
        irq_en       = ie;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234abcd));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset");

        // R5: idle mode ignores both directions
        set_mode(1'b0, 1'b0, 1'b1);
        pin_event(1'b1, 16'h1111, 1'b0, "R5 idle rise");
        pin_event(1'b0, 16'h2222, 1'b0, "R5 idle fall");

        // R2: rising only
        set_mode(1'b1, 1'b0, 1'b1);
        pin_event(1'b1, 16'hA5C3, 1'b0, "R2 rise capture R6");
        pin_event(1'b0, 16'h3C3C, 1'b0, "R2 fall ignored");

        // R12: timer keeps running, value held
        repeat (10) begin
            @(negedge clk);
            timer_val = 16'($urandom);
        end
        @(negedge clk);
        check_all("R12 hold");

        // R8 clear, R10 irq with enable off
        pulse_clear("R8 clear");
        set_mode(1'b0, 1'b1, 1'b0);
        // R3: falling only
        pin_event(1'b1, 16'h0F0F, 1'b0, "R3 rise ignored");
        pin_event(1'b0, 16'hFFFF, 1'b0, "R3 fall capture");
        // R7 sticky across idle cycles and R11 overwrite
        repeat (5) @(negedge clk);
        check_all("R7 sticky");
        set_mode(1'b1, 1'b1, 1'b1);
        pin_event(1'b1, 16'h8001, 1'b0, "R4 any rise R11 overwrite");
        pin_event(1'b0, 16'h0000, 1'b0, "R4 any fall");
        // R9 set wins over clear
        pin_event(1'b1, 16'h5A5A, 1'b1, "R9 set wins");
        pulse_clear("R8 clear after R9");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [3:0] rnd;
            rnd = 4'($urandom);
            set_mode(rnd[0], rnd[1], rnd[2]);
            pin_event(~pin_lvl ^ (($urandom % 5) == 0), 16'($urandom), rnd[3], "R4 random R6");
            if (($urandom % 4) == 0) pulse_clear("R8 random clear");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule